// File: doc/BRIEF.md
# Pipelined Carry-Save Tree Multiplier

This block multiplies two 6-bit unsigned operands in a five-stage pipeline and returns a 12-bit product. The first stage turns the multiplier bits into six shifted copies of the multiplicand. A row is zero wherever its multiplier bit is clear.

Three pipelined levels of three-to-two carry-save adders reduce those six rows to one sum vector and one carry vector. Four carry-save adders are used in total: two in the first level, one in the second and one in the third. None of them chains carries across bit positions. A ripple carry-propagate adder in the final stage combines the two vectors into the product.

A new operand pair may be presented on every clock. Each result appears, in issue order, exactly five clocks after its pair was accepted. Upstream logic drives a pair with its valid bit. Downstream logic captures the product whenever the output valid bit is high.

Top module: `csa_tree_mul`

## Requirements
- R1: When `out_valid` is 1, `out_prod` equals the unsigned product `in_a * in_b` of the pair accepted five clocks earlier. All 12 bits are kept, including the corner cases 0, 1 and 63×63 = 3969.
- R2: `out_valid` at a rising edge equals the `in_valid` value sampled five rising edges earlier, provided none of those edges was in reset.
- R3: Pairs accepted on consecutive clocks produce results on consecutive clocks, in the order they were accepted, with no stall or gap.
- R4: `rst` is synchronous and active high. The edge after it is sampled high leaves `out_valid` = 0 and `out_prod` = 0. Pairs that are in flight or presented during reset never produce a valid result.
- R5: A pair presented with `in_valid` = 0 has no effect on the product. Whenever `out_valid` is 0, `out_prod` reads 0, whatever the operand values.
- R6: At each level of the carry-save tree, the stored vectors add up, modulo 4096, to the product carried in that pipeline slot. A carry vector carries one bit position more weight than the sum vector it pairs with.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair on `in_a`/`in_b` is valid this cycle |
| in_a | input | 6 | Multiplicand, unsigned |
| in_b | input | 6 | Multiplier, unsigned |
| out_valid | output | 1 | `out_prod` holds a result this cycle |
| out_prod | output | 12 | Unsigned product |

## Verification
The bound checker tests several properties on every cycle:
- the five-clock valid latency;
- the product against a reference multiply of the operands seen five clocks before;
- the zero product on idle slots;
- sum preservation across each carry-save level, which exposes a misweighted carry vector right where it enters the tree.

Only the bench scenarios can show the rest. The exhaustive sweep of all 4096 pairs covers every operand value, and back-to-back issue shows that throughput and ordering hold. Reset is applied with the pipeline full and pairs still arriving, and the bench then shows that the pipeline is flushed.

// File: rtl/csamul_pkg.sv
`timescale 1ns/1ps
package csamul_pkg;
  // Pipeline depth from operand capture to registered product.
  localparam int unsigned PIPE_STAGES = 5;
  // Number of partial-product rows the carry-save tree is shaped for.
  localparam int unsigned TREE_ROWS   = 6;
  // Number of vectors held after the first reduction level.
  localparam int unsigned LVL1_VECS   = 4;
  // Number of vectors held after the second reduction level.
  localparam int unsigned LVL2_VECS   = 3;
endpackage

// File: rtl/fa_cell.sv
`timescale 1ns/1ps
module fa_cell (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ ci;
  assign co = (a & b) | (a & ci) | (b & ci);
endmodule

// File: rtl/ppgen.sv
`timescale 1ns/1ps
// Partial-product generator: one row per multiplier bit, each row the
// multiplicand shifted to that bit's weight, gated by the bit and the enable.
module ppgen #(
  parameter int unsigned OPW = 6,
  parameter int unsigned PW  = 2 * OPW
) (
  input  logic                    en,
  input  logic [OPW-1:0]          a,
  input  logic [OPW-1:0]          b,
  output logic [OPW-1:0][PW-1:0]  rows
);
  localparam int unsigned PADW = PW - OPW;

  logic [PW-1:0] a_ext;
  assign a_ext = {{PADW{1'b0}}, a};

  for (genvar i = 0; i < OPW; i++) begin : g_row
    assign rows[i] = (en && b[i]) ? (a_ext << i) : '0;
  end
endmodule

// File: rtl/csa3.sv
`timescale 1ns/1ps
// Three-to-two carry-save adder. Carries never ripple: each bit's carry-out
// is emitted one position higher in the carry vector.
module csa3 #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] sum,
  output logic [W-1:0] cyv
);
  assign cyv[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < W - 1) begin : g_fa
      fa_cell u_fa (
        .a (x[i]),
        .b (y[i]),
        .ci(z[i]),
        .s (sum[i]),
        .co(cyv[i+1])
      );
    end else begin : g_top
      // Carry out of the top bit is beyond the product width.
      assign sum[i] = x[i] ^ y[i] ^ z[i];
    end
  end
endmodule

// File: rtl/cpa_ripple.sv
`timescale 1ns/1ps
// Carry-propagate adder built as a chain of full adders.
module cpa_ripple #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum
);
  logic [W-1:0] cr;
  assign cr[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < W - 1) begin : g_fa
      fa_cell u_fa (
        .a (x[i]),
        .b (y[i]),
        .ci(cr[i]),
        .s (sum[i]),
        .co(cr[i+1])
      );
    end else begin : g_top
      assign sum[i] = x[i] ^ y[i] ^ cr[i];
    end
  end
endmodule

// File: rtl/csa_tree_mul.sv
`timescale 1ns/1ps
module csa_tree_mul
  import csamul_pkg::*;
#(
  parameter int unsigned OPW = 6,
  parameter int unsigned PW  = 2 * OPW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [OPW-1:0] in_a,
  input  logic [OPW-1:0] in_b,
  output logic           out_valid,
  output logic [PW-1:0]  out_prod
);
  // Valid bit travels alongside the data through all stages.
  logic [PIPE_STAGES-1:0] vld_q;

  // Stage 1: partial-product rows.
  logic [OPW-1:0][PW-1:0] rows_d;
  logic [OPW-1:0][PW-1:0] st1_q;

  // Stage 2: two CSAs, six rows to four vectors.
  logic [PW-1:0] s_a, c_a, s_b, c_b;
  logic [LVL1_VECS-1:0][PW-1:0] st2_q;

  // Stage 3: one CSA on three vectors, fourth passes by.
  logic [PW-1:0] s_c, c_c;
  logic [LVL2_VECS-1:0][PW-1:0] st3_q;

  // Stage 4: final CSA, three vectors to sum and carry.
  logic [PW-1:0] s_d, c_d;
  logic [PW-1:0] st4_s_q, st4_c_q;

  // Stage 5: carry-propagate add.
  logic [PW-1:0] prod_d;
  logic [PW-1:0] st5_q;

  ppgen #(.OPW(OPW), .PW(PW)) u_pp (
    .en  (in_valid),
    .a   (in_a),
    .b   (in_b),
    .rows(rows_d)
  );

  csa3 #(.W(PW)) u_csa_l1a (
    .x(st1_q[0]), .y(st1_q[1]), .z(st1_q[2]),
    .sum(s_a), .cyv(c_a)
  );

  csa3 #(.W(PW)) u_csa_l1b (
    .x(st1_q[3]), .y(st1_q[4]), .z(st1_q[5]),
    .sum(s_b), .cyv(c_b)
  );

  csa3 #(.W(PW)) u_csa_l2 (
    .x(st2_q[0]), .y(st2_q[1]), .z(st2_q[2]),
    .sum(s_c), .cyv(c_c)
  );

  csa3 #(.W(PW)) u_csa_l3 (
    .x(st3_q[0]), .y(st3_q[1]), .z(st3_q[2]),
    .sum(s_d), .cyv(c_d)
  );

  cpa_ripple #(.W(PW)) u_cpa (
    .x  (st4_s_q),
    .y  (st4_c_q),
    .sum(prod_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= '0;
      st1_q   <= '0;
      st2_q   <= '0;
      st3_q   <= '0;
      st4_s_q <= '0;
      st4_c_q <= '0;
      st5_q   <= '0;
    end else begin
      vld_q   <= {vld_q[PIPE_STAGES-2:0], in_valid};
      st1_q   <= rows_d;
      st2_q   <= {c_b, s_b, c_a, s_a};
      st3_q   <= {st2_q[3], c_c, s_c};
      st4_s_q <= s_d;
      st4_c_q <= c_d;
      st5_q   <= prod_d;
    end
  end

  assign out_valid = vld_q[PIPE_STAGES-1];
  assign out_prod  = st5_q;
endmodule

// File: rtl/csa_tree_mul_chk.sv
`timescale 1ns/1ps
module csa_tree_mul_chk
  import csamul_pkg::*;
#(
  parameter int unsigned OPW = 6,
  parameter int unsigned PW  = 2 * OPW
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          in_valid,
  input logic [OPW-1:0]                in_a,
  input logic [OPW-1:0]                in_b,
  input logic                          out_valid,
  input logic [PW-1:0]                 out_prod,
  input logic [LVL1_VECS-1:0][PW-1:0]  st2_q,
  input logic [LVL2_VECS-1:0][PW-1:0]  st3_q,
  input logic [PW-1:0]                 st4_s_q,
  input logic [PW-1:0]                 st4_c_q
);
  // Counts clean edges since reset, saturating, to guard $past windows.
  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  function automatic logic [PW-1:0] ref_mul(input logic v,
                                            input logic [OPW-1:0] a,
                                            input logic [OPW-1:0] b);
    logic [PW-1:0] ax, bx;
    ax = PW'(a);
    bx = PW'(b);
    return v ? PW'(ax * bx) : '0;
  endfunction

  function automatic logic [PW-1:0] sum4(input logic [LVL1_VECS-1:0][PW-1:0] v);
    return PW'(v[0] + v[1] + v[2] + v[3]);
  endfunction

  function automatic logic [PW-1:0] sum3(input logic [LVL2_VECS-1:0][PW-1:0] v);
    return PW'(v[0] + v[1] + v[2]);
  endfunction

  // R2: output valid is the input valid delayed by five clean edges.
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd5) |-> (out_valid == $past(in_valid, 5)));

  // R1: product matches a reference multiply of the pair five clocks back.
  p_product_r1: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd5 && out_valid) |->
      (out_prod == ref_mul(1'b1, $past(in_a, 5), $past(in_b, 5))));

  // R5: idle slots read as zero.
  p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_prod == '0));

  // R6: first-level vectors add to the product entered two clocks earlier.
  p_lvl1_sum_r6: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd2) |->
      (sum4(st2_q) == ref_mul($past(in_valid, 2), $past(in_a, 2), $past(in_b, 2))));

  // R6: second level preserves the slot's total.
  p_lvl2_sum_r6: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd3) |-> (sum3(st3_q) == $past(sum4(st2_q))));

  // R6: third level preserves the slot's total.
  p_lvl3_sum_r6: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd4) |-> (PW'(st4_s_q + st4_c_q) == $past(sum3(st3_q))));
endmodule

bind csa_tree_mul csa_tree_mul_chk #(.OPW(OPW), .PW(PW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_a     (in_a),
  .in_b     (in_b),
  .out_valid(out_valid),
  .out_prod (out_prod),
  .st2_q    (st2_q),
  .st3_q    (st3_q),
  .st4_s_q  (st4_s_q),
  .st4_c_q  (st4_c_q)
);

// File: tb/sim_csa_tree_mul.sv
`timescale 1ns/1ps
module sim_csa_tree_mul;
  localparam int OPW = 6;
  localparam int PW  = 2 * OPW;
  localparam int LAT = 5;
  localparam int NMAX = 4096;
  localparam real CLK_NS = 4.0;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [OPW-1:0] in_a = '0;
  logic [OPW-1:0] in_b = '0;
  logic           out_valid;
  logic [PW-1:0]  out_prod;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  logic           st_v [NMAX];
  logic [OPW-1:0] st_a [NMAX];
  logic [OPW-1:0] st_b [NMAX];

  always #(CLK_NS / 2.0) clk = ~clk;

  csa_tree_mul #(.OPW(OPW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_prod(out_prod)
  );

  task automatic check(input bit ok, input string req,
                       input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // Drive n entries from the stimulus arrays on consecutive clocks and
  // check each result LAT clocks later. Idle entries must read as zero.
  task automatic run_stream(input int n, input string req);
    for (int c = 0; c < n + LAT; c++) begin
      @(negedge clk);
      if (c >= LAT) begin
        int k;
        int e;
        k = c - LAT;
        e = st_v[k] ? int'(st_a[k]) * int'(st_b[k]) : 0;
        check(out_valid == st_v[k], {req, " valid"}, int'(out_valid), int'(st_v[k]));
        check(int'(out_prod) == e, {req, " product"}, int'(out_prod), e);
      end
      if (c < n) begin
        in_valid = st_v[c];
        in_a     = st_a[c];
        in_b     = st_b[c];
      end else begin
        in_valid = 1'b0;
        in_a     = 6'h2A;
        in_b     = 6'h15;
      end
    end
  endtask

  // R4: reset state, with operands offered during reset being dropped.
  task automatic t_reset_state();
    rst = 1'b1;
    in_valid = 1'b1; in_a = 6'd63; in_b = 6'd63;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R4 reset valid", int'(out_valid), 0);
    check(out_prod == '0, "R4 reset product", int'(out_prod), 0);
    rst = 1'b0; in_valid = 1'b0;
    for (int i = 0; i < LAT + 1; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R4 flush valid", int'(out_valid), 0);
      check(out_prod == '0, "R4 flush product", int'(out_prod), 0);
    end
  endtask

  // R1/R3/R6: all 4096 pairs issued back to back.
  task automatic t_exhaustive();
    for (int i = 0; i < NMAX; i++) begin
      st_v[i] = 1'b1;
      st_a[i] = OPW'(i >> OPW);
      st_b[i] = OPW'(i);
    end
    run_stream(NMAX, "R1 R3 R6 exhaustive");
  endtask

  // R2/R5: valid with gaps; idle slots carry nonzero operands.
  task automatic t_bubbles();
    for (int i = 0; i < 48; i++) begin
      st_v[i] = (i % 3 != 0) && (i % 7 != 5);
      st_a[i] = OPW'(i * 37 + 5);
      st_b[i] = OPW'(i * 11 + 3);
    end
    run_stream(48, "R2 R5 bubbles");
  endtask

  // R1: operand corners, each isolated by an idle slot.
  task automatic t_corners();
    logic [OPW-1:0] ca [8] = '{6'd0, 6'd63, 6'd63, 6'd1, 6'd32, 6'd63, 6'd42, 6'd1};
    logic [OPW-1:0] cb [8] = '{6'd63, 6'd0, 6'd63, 6'd1, 6'd32, 6'd1, 6'd21, 6'd63};
    for (int i = 0; i < 8; i++) begin
      st_v[2*i]   = 1'b1;
      st_a[2*i]   = ca[i];
      st_b[2*i]   = cb[i];
      st_v[2*i+1] = 1'b0;
      st_a[2*i+1] = 6'd63;
      st_b[2*i+1] = 6'd63;
    end
    run_stream(16, "R1 corners");
  endtask

  // R4: reset while the pipeline is full drops every in-flight result.
  task automatic t_mid_reset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_a = OPW'(50 + i); in_b = OPW'(60 - i);
    end
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R4 mid reset valid", int'(out_valid), 0);
    check(out_prod == '0, "R4 mid reset product", int'(out_prod), 0);
    rst = 1'b0; in_valid = 1'b0;
    for (int i = 0; i < LAT + 2; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R4 mid reset flush", int'(out_valid), 0);
    end
  endtask

  initial begin
    t_reset_state();
    t_exhaustive();
    t_bubbles();
    t_corners();
    t_mid_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000.0);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule